// File: doc/BRIEF.md
# Translated DMA Channel Engine

This block moves data between a byte-stream device and system memory for eight DMA channels. Each channel has its own enable, direction, logical address and remaining-count registers. Device-side addresses are logical. The engine maps them to physical memory through a page table that lives in system memory, bounded by a base register and a limit register. Only one request is served at a time. A request names a channel, a direction and a length, and the engine returns a single done pulse when it has finished.

For each request the engine first clears the channel's status flags. It then checks that the channel is enabled and that its direction bit agrees with the request. If the check fails, the engine flags a memory error, latches the channel in a shared interrupt-source register, and finishes without touching memory. If the check passes, it clamps the length to the remaining count and walks the transfer page by page. For each page it fetches one table entry and then moves the bytes one at a time over a word-wide valid/ready memory master. When it finishes, it sets the terminal-count flag and subtracts the clamped length from the count.

Software programs the channels through a word-indexed register port whose read data is registered.

Top module: `tdma_engine`

## Requirements
- R1: After reset, all channel registers, the table base, the table limit and the interrupt-source register read zero. `mem_valid` and `done` are low and `req_ready` is high.
- R2: Every accepted request clears the channel's terminal-count (bit 8), memory-error (bit 9) and address-error (bit 10) flags in its control word before it sets any new flag.
- R3: A request on a channel whose enable bit (control bit 0) is clear is rejected. On rejection the engine sets memory-error, sets bit n of the interrupt-source register (word 34), pulses `done` and issues no memory access.
- R4: A request is also rejected if its direction disagrees with control bit 1 (memory-to-device). A request with `req_to_mem`=1 is legal only when that bit is 0, and a request with `req_to_mem`=0 is legal only when it is 1.
- R5: Writing ones to the interrupt-source register clears those bits and leaves the others unchanged.
- R6: The transfer length is the smaller of `req_len` and the channel's count register (word n*4+2). The transfer starts at the channel's address register (word n*4+1).
- R7: The transfer never crosses a 4 KiB page within one table lookup. For each page the engine reads one 32-bit frame word at table base (word 32) plus page index times 8.
- R8: Each byte goes to or from frame plus page offset as one memory access. A write carries the byte in every lane, with `mem_be` = 1 << addr[1:0]. A read takes lane addr[1:0] of `mem_rdata`. Neighbouring bytes are never disturbed.
- R9: If a page index is at or above the table limit (word 33) divided by 8, the transfer stops early with no further memory access.
- R10: When a request that passed its checks finishes, including one that stopped early, the terminal-count flag is set, the full clamped length is subtracted from the count, and `done` pulses for exactly one cycle.
- R11: Device bytes are moved in stream order: the k-th byte taken from `dev_in_data`, or the k-th byte sent on `dev_out_data`, belongs to logical address start + k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Engine idle; request is taken on valid and ready |
| req_ch | input | 3 | Channel number |
| req_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| req_len | input | 16 | Requested byte count |
| done | output | 1 | One-cycle pulse at the end of a request |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Memory completes the access |
| dev_in_valid | input | 1 | Device byte available |
| dev_in_ready | output | 1 | Engine takes the device byte |
| dev_in_data | input | 8 | Device byte toward memory |
| dev_out_valid | output | 1 | Byte for the device |
| dev_out_ready | input | 1 | Device takes the byte |
| dev_out_data | output | 8 | Byte from memory |

## Verification
The translation path is tried in four ways:
- A device-to-memory run that starts four bytes before a page end. It must fetch two different table entries, which separates the page split from a single linear mapping, and its request length is larger than the count, which exercises the clamp.
- A memory-to-device run whose second page lies beyond the table limit. It shows the early stop and confirms that the count is still reduced by the full amount.
- A short aligned write inside a pre-filled word. It exposes any wrong byte lane.
- Rejections for a disabled channel and for each direction mismatch. They show that no memory traffic occurs and that the previous flags are cleared.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_CHUNK,
    ST_TBL,
    ST_GET,
    ST_PUT,
    ST_FIN
  } eng_state_t;
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs
  import tdma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int AW = CH_W + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic [CH_W-1:0] eng_ch,
  input  logic            eng_clr,
  input  logic            eng_memerr,
  input  logic            eng_tc,
  input  logic [DW-1:0]   eng_sub,
  output logic            ch_en,
  output logic            ch_m2d,
  output logic [DW-1:0]   ch_addr,
  output logic [DW-1:0]   ch_count,
  output logic [DW-1:0]   tbl_base,
  output logic [DW-1:0]   tbl_limit
);
  localparam logic [1:0] F_CTRL = 2'd0;
  localparam logic [1:0] F_ADDR = 2'd1;
  localparam logic [1:0] F_CNT  = 2'd2;
  localparam logic [1:0] G_BASE = 2'd0;
  localparam logic [1:0] G_LIM  = 2'd1;
  localparam logic [1:0] G_IRQ  = 2'd2;

  logic            in_ch;
  logic [CH_W-1:0] sel_ch;
  logic [1:0]      sel_f;
  logic            glob_ok;

  assign in_ch   = ~cfg_addr[AW-1];
  assign sel_ch  = cfg_addr[AW-2:2];
  assign sel_f   = cfg_addr[1:0];
  assign glob_ok = ~in_ch && (sel_ch == '0);

  logic [NCH-1:0] en_v, m2d_v, tc_v, me_v, ae_v;
  logic [DW-1:0]  addr_v [NCH];
  logic [DW-1:0]  cnt_v  [NCH];
  logic [NCH-1:0] irq_q;
  logic [DW-1:0]  base_q, lim_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          en_q, m2d_q, tc_q, me_q, ae_q;
    logic [DW-1:0] addr_q, cnt_q;
    logic          hit_w, hit_e;

    assign hit_w = cfg_we && in_ch && (sel_ch == CH_W'(g));
    assign hit_e = (eng_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= 1'b0; m2d_q <= 1'b0;
        tc_q <= 1'b0; me_q <= 1'b0; ae_q <= 1'b0;
        addr_q <= '0; cnt_q <= '0;
      end else begin
        if (hit_w) begin
          case (sel_f)
            F_CTRL: begin en_q <= cfg_wdata[0]; m2d_q <= cfg_wdata[1]; end
            F_ADDR: addr_q <= cfg_wdata;
            F_CNT:  cnt_q  <= cfg_wdata;
            default: ;
          endcase
        end
        if (eng_clr && hit_e) begin
          tc_q <= 1'b0; me_q <= 1'b0; ae_q <= 1'b0;
        end
        if (eng_memerr && hit_e) me_q <= 1'b1;
        if (eng_tc && hit_e) begin
          tc_q  <= 1'b1;
          cnt_q <= cnt_q - eng_sub;
        end
      end
    end

    assign en_v[g]   = en_q;
    assign m2d_v[g]  = m2d_q;
    assign tc_v[g]   = tc_q;
    assign me_v[g]   = me_q;
    assign ae_v[g]   = ae_q;
    assign addr_v[g] = addr_q;
    assign cnt_v[g]  = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lim_q  <= '0;
      irq_q  <= '0;
    end else begin
      if (cfg_we && glob_ok && sel_f == G_BASE) base_q <= cfg_wdata;
      if (cfg_we && glob_ok && sel_f == G_LIM)  lim_q  <= cfg_wdata;
      irq_q <= (irq_q & ~((cfg_we && glob_ok && sel_f == G_IRQ) ? cfg_wdata[NCH-1:0] : '0))
             | (eng_memerr ? (NCH'(1) << eng_ch) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (in_ch) begin
      case (sel_f)
        F_CTRL:  cfg_rdata <= {21'b0, ae_v[sel_ch], me_v[sel_ch], tc_v[sel_ch],
                               6'b0, m2d_v[sel_ch], en_v[sel_ch]};
        F_ADDR:  cfg_rdata <= addr_v[sel_ch];
        F_CNT:   cfg_rdata <= cnt_v[sel_ch];
        default: cfg_rdata <= '0;
      endcase
    end else if (glob_ok) begin
      case (sel_f)
        G_BASE:  cfg_rdata <= base_q;
        G_LIM:   cfg_rdata <= lim_q;
        G_IRQ:   cfg_rdata <= DW'(irq_q);
        default: cfg_rdata <= '0;
      endcase
    end else begin
      cfg_rdata <= '0;
    end
  end

  assign ch_en     = en_v[eng_ch];
  assign ch_m2d    = m2d_v[eng_ch];
  assign ch_addr   = addr_v[eng_ch];
  assign ch_count  = cnt_v[eng_ch];
  assign tbl_base  = base_q;
  assign tbl_limit = lim_q;

  AST_IRQ_ON_REJECT: assert property (@(posedge clk) disable iff (rst)
    eng_memerr |=> irq_q[$past(eng_ch)]);  // R3

  AST_SUB_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    eng_tc |-> (eng_sub <= ch_count));  // R6
endmodule

// File: rtl/tdma_xlate.sv
module tdma_xlate
  import tdma_pkg::*;
#(
  parameter int PAGE_BITS  = 12,
  parameter int ENTRY_BITS = 3,
  localparam int PAGE = 1 << PAGE_BITS
) (
  input  logic [DW-1:0] cur_addr,
  input  logic [DW-1:0] left,
  input  logic [DW-1:0] tbl_base,
  input  logic [DW-1:0] tbl_limit,
  output logic [DW-1:0] page_off,
  output logic          over_limit,
  output logic [DW-1:0] chunk_len,
  output logic [DW-1:0] entry_addr
);
  logic [DW-1:0] idx, room;

  always_comb begin
    page_off   = DW'(cur_addr[PAGE_BITS-1:0]);
    idx        = cur_addr >> PAGE_BITS;
    over_limit = idx >= (tbl_limit >> ENTRY_BITS);
    room       = DW'(PAGE) - page_off;
    chunk_len  = (room < left) ? room : left;
    entry_addr = tbl_base + (idx << ENTRY_BITS);
  end
endmodule

// File: rtl/tdma_ctrl.sv
module tdma_ctrl
  import tdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int LEN_W = 16,
  parameter int PAGE_BITS = 12,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_ch,
  input  logic             req_to_mem,
  input  logic [LEN_W-1:0] req_len,
  output logic             done,
  output logic [CH_W-1:0]  eng_ch,
  output logic             eng_clr,
  output logic             eng_memerr,
  output logic             eng_tc,
  output logic [DW-1:0]    eng_sub,
  input  logic             ch_en,
  input  logic             ch_m2d,
  input  logic [DW-1:0]    ch_addr,
  input  logic [DW-1:0]    ch_count,
  output logic [DW-1:0]    cur_addr,
  output logic [DW-1:0]    left,
  input  logic [DW-1:0]    xl_off,
  input  logic             xl_over,
  input  logic [DW-1:0]    xl_chunk,
  input  logic [DW-1:0]    xl_entry,
  output logic             mem_valid,
  output logic             mem_write,
  output logic [DW-1:0]    mem_addr,
  output logic [3:0]       mem_be,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  input  logic             dev_in_valid,
  output logic             dev_in_ready,
  input  logic [7:0]       dev_in_data,
  output logic             dev_out_valid,
  input  logic             dev_out_ready,
  output logic [7:0]       dev_out_data
);
  eng_state_t       st;
  logic [CH_W-1:0]  ch_q;
  logic             to_mem_q, rej_q;
  logic [LEN_W-1:0] len_q;
  logic [DW-1:0]    clamp_q, cur_q, left_q, chunk_q, phys_q, ent_q;
  logic [7:0]       byte_q, lane_b;
  logic             reject, step;
  logic [DW-1:0]    len_x, clamp_n;

  assign reject  = !ch_en || (to_mem_q == ch_m2d);
  assign len_x   = DW'(len_q);
  assign clamp_n = (len_x > ch_count) ? ch_count : len_x;
  assign step    = (st == ST_PUT) && (to_mem_q ? mem_ready : dev_out_ready);

  always_comb begin
    case (phys_q[1:0])
      2'd0:    lane_b = mem_rdata[7:0];
      2'd1:    lane_b = mem_rdata[15:8];
      2'd2:    lane_b = mem_rdata[23:16];
      default: lane_b = mem_rdata[31:24];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      ch_q <= '0; to_mem_q <= 1'b0; rej_q <= 1'b0; len_q <= '0;
      clamp_q <= '0; cur_q <= '0; left_q <= '0; chunk_q <= '0;
      phys_q <= '0; ent_q <= '0; byte_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          ch_q     <= req_ch;
          to_mem_q <= req_to_mem;
          len_q    <= req_len;
          st       <= ST_CHECK;
        end
        ST_CHECK: begin
          if (reject) begin
            rej_q <= 1'b1;
            st    <= ST_FIN;
          end else begin
            rej_q   <= 1'b0;
            clamp_q <= clamp_n;
            left_q  <= clamp_n;
            cur_q   <= ch_addr;
            st      <= ST_CHUNK;
          end
        end
        ST_CHUNK: begin
          if (left_q == '0 || xl_over) begin
            st <= ST_FIN;
          end else begin
            chunk_q <= xl_chunk;
            ent_q   <= xl_entry;
            st      <= ST_TBL;
          end
        end
        ST_TBL: if (mem_ready) begin
          phys_q <= mem_rdata + xl_off;
          st     <= ST_GET;
        end
        ST_GET: begin
          if (to_mem_q) begin
            if (dev_in_valid) begin
              byte_q <= dev_in_data;
              st     <= ST_PUT;
            end
          end else if (mem_ready) begin
            byte_q <= lane_b;
            st     <= ST_PUT;
          end
        end
        ST_PUT: if (step) begin
          phys_q  <= phys_q + 1'b1;
          cur_q   <= cur_q + 1'b1;
          left_q  <= left_q - 1'b1;
          chunk_q <= chunk_q - 1'b1;
          st      <= (chunk_q == DW'(1)) ? ST_CHUNK : ST_GET;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign done          = (st == ST_FIN);
  assign eng_ch        = ch_q;
  assign eng_clr       = (st == ST_CHECK);
  assign eng_memerr    = (st == ST_CHECK) && reject;
  assign eng_tc        = (st == ST_FIN) && !rej_q;
  assign eng_sub       = clamp_q;
  assign cur_addr      = cur_q;
  assign left          = left_q;
  assign mem_valid     = (st == ST_TBL) || (st == ST_GET && !to_mem_q)
                       || (st == ST_PUT && to_mem_q);
  assign mem_write     = (st == ST_PUT) && to_mem_q;
  assign mem_addr      = (st == ST_TBL) ? ent_q : phys_q;
  assign mem_be        = mem_write ? (4'b0001 << phys_q[1:0]) : 4'b1111;
  assign mem_wdata     = {4{byte_q}};
  assign dev_in_ready  = (st == ST_GET) && to_mem_q;
  assign dev_out_valid = (st == ST_PUT) && !to_mem_q;
  assign dev_out_data  = byte_q;

  AST_REJECT_ENDS: assert property (@(posedge clk) disable iff (rst)
    eng_memerr |=> (done && !eng_tc && !mem_valid));  // R3

  AST_STAY_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    (step && chunk_q != DW'(1)) |=>
      (cur_q[DW-1:PAGE_BITS] == $past(cur_q[DW-1:PAGE_BITS])));  // R7

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write)));  // R8

  AST_LIMIT_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TBL) |-> !xl_over);  // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R10
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
  import tdma_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int LEN_W      = 16,
  parameter int PAGE_BITS  = 12,
  parameter int ENTRY_BITS = 3,
  localparam int CH_W = $clog2(NCH),
  localparam int AW   = CH_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_ch,
  input  logic             req_to_mem,
  input  logic [LEN_W-1:0] req_len,
  output logic             done,
  output logic             mem_valid,
  output logic             mem_write,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ready,
  input  logic             dev_in_valid,
  output logic             dev_in_ready,
  input  logic [7:0]       dev_in_data,
  output logic             dev_out_valid,
  input  logic             dev_out_ready,
  output logic [7:0]       dev_out_data
);
  logic [CH_W-1:0] eng_ch;
  logic            eng_clr, eng_memerr, eng_tc;
  logic [DW-1:0]   eng_sub, ch_addr, ch_count, tbl_base, tbl_limit;
  logic            ch_en, ch_m2d;
  logic [DW-1:0]   cur_addr, left, xl_off, xl_chunk, xl_entry;
  logic            xl_over;

  tdma_regs #(.NCH(NCH)) u_regs (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .eng_ch, .eng_clr, .eng_memerr, .eng_tc, .eng_sub,
    .ch_en, .ch_m2d, .ch_addr, .ch_count, .tbl_base, .tbl_limit
  );

  tdma_xlate #(.PAGE_BITS(PAGE_BITS), .ENTRY_BITS(ENTRY_BITS)) u_xlate (
    .cur_addr, .left, .tbl_base, .tbl_limit,
    .page_off(xl_off), .over_limit(xl_over),
    .chunk_len(xl_chunk), .entry_addr(xl_entry)
  );

  tdma_ctrl #(.NCH(NCH), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk, .rst, .req_valid, .req_ready, .req_ch, .req_to_mem, .req_len, .done,
    .eng_ch, .eng_clr, .eng_memerr, .eng_tc, .eng_sub,
    .ch_en, .ch_m2d, .ch_addr, .ch_count,
    .cur_addr, .left, .xl_off, .xl_over, .xl_chunk, .xl_entry,
    .mem_valid, .mem_write, .mem_addr, .mem_be, .mem_wdata, .mem_rdata, .mem_ready,
    .dev_in_valid, .dev_in_ready, .dev_in_data,
    .dev_out_valid, .dev_out_ready, .dev_out_data
  );
endmodule

// File: tb/test_tdma_engine.sv
`timescale 1ns/1ps
module test_tdma_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_ch = '0;
  logic        req_to_mem = 1'b0;
  logic [15:0] req_len = '0;
  logic        done;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        dev_in_valid;
  logic        dev_in_ready;
  logic [7:0]  dev_in_data;
  logic        dev_out_valid;
  logic        dev_out_ready;
  logic [7:0]  dev_out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] bmem [0:4095];
  logic [7:0]  src [0:63];
  logic [7:0]  olog [0:63];
  int src_idx = 0;
  int ocnt = 0;
  int acc_n = 0;
  int tbl_n = 0;

  always #2 clk = ~clk;

  tdma_engine i_tdma_engine (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .req_valid, .req_ready, .req_ch, .req_to_mem, .req_len, .done,
    .mem_valid, .mem_write, .mem_addr, .mem_be, .mem_wdata, .mem_rdata, .mem_ready,
    .dev_in_valid, .dev_in_ready, .dev_in_data,
    .dev_out_valid, .dev_out_ready, .dev_out_data
  );

  assign dev_in_valid  = 1'b1;
  assign dev_in_data   = src[src_idx[5:0]];
  assign dev_out_ready = 1'b1;

  // memory model: one-cycle registered ready
  always @(posedge clk) begin
    mem_ready <= mem_valid && !mem_ready;
    mem_rdata <= bmem[mem_addr[13:2]];
    if (mem_valid && mem_ready) begin
      acc_n <= acc_n + 1;
      if (!mem_write && mem_addr >= 32'h100 && mem_addr < 32'h140) tbl_n <= tbl_n + 1;
      if (mem_write) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) bmem[mem_addr[13:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end
    end
    if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
    if (dev_out_valid && dev_out_ready) begin
      olog[ocnt[5:0]] <= dev_out_data;
      ocnt <= ocnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic run_req(input logic [2:0] ch, input logic tm, input logic [15:0] len,
                         output int accs, output int tbls);
    int a0, t0;
    bit seen;
    a0 = acc_n; t0 = tbl_n;
    @(negedge clk);
    req_valid = 1'b1; req_ch = ch; req_to_mem = tm; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk("R10 done pulse seen", {31'b0, seen}, 32'd1);
    @(negedge clk);
    chk("R10 done is one cycle", {31'b0, done}, 32'd0);
    accs = acc_n - a0;
    tbls = tbl_n - t0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 mem_valid low", {31'b0, mem_valid}, 0);
    chk("R1 done low", {31'b0, done}, 0);
    chk("R1 req_ready high", {31'b0, req_ready}, 1);
    rd(6'd0, v);  chk("R1 ch0 ctrl", v, 0);
    rd(6'd30, v); chk("R1 ch7 count", v, 0);
    rd(6'd32, v); chk("R1 table base", v, 0);
    rd(6'd33, v); chk("R1 table limit", v, 0);
    rd(6'd34, v); chk("R1 irq source", v, 0);
  endtask

  task automatic t_reject_disabled();
    logic [31:0] v; int a, t;
    wr(6'd8, 32'h0);
    run_req(3'd2, 1'b1, 16'd4, a, t);
    chk("R3 no memory access", a, 0);
    rd(6'd8, v);  chk("R3 memerr flag ch2", v, 32'h200);
    rd(6'd34, v); chk("R3 irq bit 2", v, 32'h04);
  endtask

  task automatic t_reject_dir();
    logic [31:0] v; int a, t;
    wr(6'd20, 32'h3);
    run_req(3'd5, 1'b1, 16'd4, a, t);
    chk("R4 no memory access", a, 0);
    rd(6'd20, v); chk("R4 memerr flag ch5", v, 32'h203);
    rd(6'd34, v); chk("R4 irq bits 5,2", v, 32'h24);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(6'd34, 32'h04);
    rd(6'd34, v); chk("R5 w1c leaves bit 5", v, 32'h20);
  endtask

  task automatic t_cross_write();
    logic [31:0] v; int a, t, s0;
    s0 = src_idx;
    for (int k = 0; k < 8; k++) src[(s0 + k) % 64] = 8'hA0 + 8'(k);
    wr(6'd4, 32'h1);
    wr(6'd5, 32'h0FFC);
    wr(6'd6, 32'd6);
    run_req(3'd1, 1'b1, 16'd10, a, t);
    chk("R6 clamp: bytes taken", src_idx - s0, 6);
    chk("R7 two table reads", t, 2);
    chk("R8 total accesses", a, 8);
    chk("R11 first page bytes", bmem[32'h3FFC >> 2], 32'hA3A2A1A0);
    chk("R8 second page lanes", bmem[32'h2000 >> 2], 32'h7766A5A4);
    rd(6'd6, v); chk("R10 count drained", v, 0);
    rd(6'd4, v); chk("R10 tc flag", v, 32'h101);
  endtask

  task automatic t_flags_cleared();
    logic [31:0] v; int a, t;
    run_req(3'd1, 1'b0, 16'd1, a, t);
    rd(6'd4, v);  chk("R2 tc cleared on new request", v, 32'h201);
    rd(6'd34, v); chk("R4 irq bit 1", v, 32'h22);
    chk("R4 mismatch no access", a, 0);
  endtask

  task automatic t_limit_read();
    logic [31:0] v; int a, t, o0;
    o0 = ocnt;
    wr(6'd4, 32'h3);
    wr(6'd5, 32'h1FFE);
    wr(6'd6, 32'd3);
    run_req(3'd1, 1'b0, 16'd5, a, t);
    chk("R9 early stop accesses", a, 3);
    chk("R9 bytes out", ocnt - o0, 2);
    chk("R11 out byte 0", {24'b0, olog[o0 % 64]}, 32'h5A);
    chk("R11 out byte 1", {24'b0, olog[(o0 + 1) % 64]}, 32'hC3);
    rd(6'd4, v);  chk("R2 memerr cleared, tc set", v, 32'h103);
    rd(6'd6, v);  chk("R10 full clamp subtracted", v, 0);
    rd(6'd34, v); chk("R9 irq unchanged", v, 32'h22);
  endtask

  task automatic t_short_write();
    logic [31:0] v; int a, t, s0;
    s0 = src_idx;
    for (int k = 0; k < 4; k++) src[(s0 + k) % 64] = 8'hB0 + 8'(k);
    wr(6'd0, 32'h1);
    wr(6'd1, 32'h0010);
    wr(6'd2, 32'd100);
    run_req(3'd0, 1'b1, 16'd4, a, t);
    chk("R8 lanes filled", bmem[32'h3010 >> 2], 32'hB3B2B1B0);
    chk("R8 neighbour untouched", bmem[32'h3014 >> 2], 32'hEEEEEEEE);
    chk("R7 one table read", t, 1);
    rd(6'd2, v); chk("R6 count minus request", v, 32'd96);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = '0;
    for (int i = 0; i < 64; i++) begin src[i] = '0; olog[i] = '0; end
    bmem[32'h100 >> 2] = 32'h3000;
    bmem[32'h108 >> 2] = 32'h2000;
    bmem[32'h110 >> 2] = 32'h1000;
    bmem[32'h2000 >> 2] = 32'h77665544;
    bmem[32'h2FFC >> 2] = 32'hC35A1122;
    bmem[32'h3014 >> 2] = 32'hEEEEEEEE;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    wr(6'd32, 32'h100);
    wr(6'd33, 32'd16);
    t_reject_disabled();
    t_reject_dir();
    t_w1c();
    t_cross_write();
    t_flags_cleared();
    t_limit_read();
    t_short_write();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule